// File: doc/BRIEF.md
# DMA Burst Splitting Engine

This block accepts one DMA transfer request at a time (a start byte address, a beat count and a direction) and turns it into a sequence of system-bus burst commands. Each command carries an address, a length in beats and the direction. Commands leave over a valid/ready handshake, one at a time. After each accepted command the engine moves its address forward by the burst length times the beat width in bytes and takes the length off the beats still owed. The request is finished when nothing is owed.

The burst length comes from configuration inputs. There is one enable for each of the lengths 16, 8 and 4, and a flag that permits bursts of any length. An alignment mode restricts each burst to addresses that are naturally aligned for its size. A separate cap for reads and for writes limits how many issued bursts may wait for completion. The bus side returns one completion pulse per finished burst. Configuration is expected to stay constant while a request is in progress.

Top module: `burst_split_engine`

## Requirements
- R1: After reset the engine is idle: `req_ready_o` is high and `cmd_valid_o` is low.
- R2: With `cfg_anylen_i` low, the length enables are tested in the order 16 (`cfg_len_en_i[2]`), 8 (`cfg_len_en_i[1]`), 4 (`cfg_len_en_i[0]`). The first enabled length not larger than the beats still owed is issued. If none qualifies, a single beat is issued. With all three enabled, 42 beats give 16, 16, 8, 1, 1.
- R3: With `cfg_anylen_i` high, the largest enabled length is used, and the last burst carries whatever smaller count is left. With only 16 enabled, 42 beats give 16, 16, 10. If no length is enabled, every burst is one beat.
- R4: With `cfg_align_i` high, an enabled length L qualifies only if the current address is a multiple of L times the beat width in bytes. Otherwise the next smaller enabled length is tried, and a single beat is used when none qualifies.
- R5: Each command's address equals the request address plus the beat width times all beats issued earlier in the request. `cmd_write_o` equals the request's direction. The lengths of one request add up to its beat count.
- R6: A request with a beat count of zero is accepted in one cycle and produces no command.
- R7: A read command is withheld while the outstanding reads equal `cfg_rd_cap_i`+1, and a write command likewise against `cfg_wr_cap_i`+1. Each `rd_done_i` or `wr_done_i` pulse frees one slot of its direction.
- R8: `req_ready_o` is high only while no request is in progress. A command held by a low `cmd_ready_i` keeps its valid, address and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_len_en_i | input | 3 | Length enables: bit 2 = 16, bit 1 = 8, bit 0 = 4 beats |
| cfg_anylen_i | input | 1 | Permit bursts of any length up to the largest enabled |
| cfg_align_i | input | 1 | Require natural address alignment per burst size |
| cfg_rd_cap_i | input | 2 | Read outstanding limit minus one |
| cfg_wr_cap_i | input | 2 | Write outstanding limit minus one |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_addr_i | input | AW | Request start byte address |
| req_beats_i | input | CW | Request beat count |
| req_write_i | input | 1 | Request direction, 1 = write |
| cmd_valid_o | output | 1 | Burst command present |
| cmd_ready_i | input | 1 | Bus takes the command |
| cmd_addr_o | output | AW | Burst start byte address |
| cmd_len_o | output | 5 | Burst length in beats |
| cmd_write_o | output | 1 | Burst direction, 1 = write |
| rd_done_i | input | 1 | One read burst finished |
| wr_done_i | input | 1 | One write burst finished |

## Verification
If the length selection is wrong, the very next command shows a bad length. The address register then moves by the wrong amount, so every later command of the request starts at a bad address. The sum of lengths misses the beat count, and the engine returns to idle either early or late. A wrong credit count shows up at the ports in one of two ways: bursts beyond the cap go out in the cycle after the limit is reached, or after a completion pulse a command stays withheld although a slot is free. Both show within two cycles of that pulse.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int NUM_SIZES = 3;
  // index 0 is the highest-priority (largest) size
  localparam int SIZE_LOG2 [NUM_SIZES] = '{4, 3, 2};
  localparam int MAX_BURST = 1 << SIZE_LOG2[0];

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bse_state_e;
endpackage

// File: rtl/bse_rst_sync.sv
module bse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/bse_len_select.sv
module bse_len_select
  import bse_pkg::*;
#(
  parameter int CW         = 16,
  parameter int BEAT_BYTES = 4,
  localparam int ALW       = SIZE_LOG2[0] + $clog2(BEAT_BYTES),
  localparam int LW        = $clog2(MAX_BURST + 1)
) (
  input  logic [NUM_SIZES-1:0] len_en_i,
  input  logic                 anylen_i,
  input  logic                 align_i,
  input  logic [ALW-1:0]       addr_lo_i,
  input  logic [CW-1:0]        rem_i,
  output logic [LW-1:0]        len_o
);
  logic [NUM_SIZES-1:0] cand_ok;
  logic [LW-1:0]        cand_len [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int SZ = 1 << SIZE_LOG2[g];
    localparam logic [ALW-1:0] AMASK = ALW'(SZ * BEAT_BYTES - 1);
    logic fits_count;
    logic fits_align;

    assign fits_count  = anylen_i || (rem_i >= CW'(SZ));
    assign fits_align  = !align_i || ((addr_lo_i & AMASK) == '0);
    assign cand_ok[g]  = len_en_i[NUM_SIZES-1-g] && fits_count && fits_align;
    assign cand_len[g] = (rem_i < CW'(SZ)) ? LW'(rem_i) : LW'(SZ);
  end

  // lowest priority first so higher priority entries override
  always_comb begin
    len_o = LW'(1);
    for (int i = NUM_SIZES - 1; i >= 0; i--) begin
      if (cand_ok[i]) len_o = cand_len[i];
    end
  end
endmodule

// File: rtl/bse_credit.sv
module bse_credit #(
  parameter int  MAX_OUT = 4,
  localparam int CAPW    = $clog2(MAX_OUT),
  localparam int NW      = $clog2(MAX_OUT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            give_i,
  input  logic [CAPW-1:0] cap_i,
  output logic            avail_o
);
  logic [NW-1:0] cnt_q, cnt_d;
  logic          give_eff;
  logic          cnt_en;

  assign give_eff = give_i && (cnt_q != '0);
  assign cnt_en   = take_i ^ give_eff;

  always_comb begin
    cnt_d = cnt_q;
    if (take_i && !give_eff)      cnt_d = cnt_q + NW'(1);
    else if (!take_i && give_eff) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign avail_o = cnt_q <= NW'(cap_i);
endmodule

// File: rtl/burst_split_engine.sv
module burst_split_engine
  import bse_pkg::*;
#(
  parameter int  AW         = 32,
  parameter int  CW         = 16,
  parameter int  BEAT_BYTES = 4,
  parameter int  MAX_OUT    = 4,
  localparam int LW         = $clog2(MAX_BURST + 1),
  localparam int CAPW       = $clog2(MAX_OUT),
  localparam int ALW        = SIZE_LOG2[0] + $clog2(BEAT_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SIZES-1:0] cfg_len_en_i,
  input  logic                 cfg_anylen_i,
  input  logic                 cfg_align_i,
  input  logic [CAPW-1:0]      cfg_rd_cap_i,
  input  logic [CAPW-1:0]      cfg_wr_cap_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [CW-1:0]        req_beats_i,
  input  logic                 req_write_i,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output logic [AW-1:0]        cmd_addr_o,
  output logic [LW-1:0]        cmd_len_o,
  output logic                 cmd_write_o,
  input  logic                 rd_done_i,
  input  logic                 wr_done_i
);
  logic        rst_sync_n;
  bse_state_e  state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic        wr_q, wr_d;
  logic        xfer_en;
  logic [LW-1:0] sel_len;
  logic [1:0]  dir_avail;
  logic        cmd_fire;

  bse_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  bse_len_select #(.CW(CW), .BEAT_BYTES(BEAT_BYTES)) u_sel (
    .len_en_i  (cfg_len_en_i),
    .anylen_i  (cfg_anylen_i),
    .align_i   (cfg_align_i),
    .addr_lo_i (addr_q[ALW-1:0]),
    .rem_i     (rem_q),
    .len_o     (sel_len)
  );

  // direction 0 = read, 1 = write
  for (genvar d = 0; d < 2; d++) begin : g_dir
    bse_credit #(.MAX_OUT(MAX_OUT)) u_credit (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .take_i  (cmd_fire && (wr_q == 1'(d))),
      .give_i  ((d == 1) ? wr_done_i : rd_done_i),
      .cap_i   ((d == 1) ? cfg_wr_cap_i : cfg_rd_cap_i),
      .avail_o (dir_avail[d])
    );
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmd_valid_o = (state_q == ST_RUN) && dir_avail[wr_q];
  assign cmd_fire    = cmd_valid_o && cmd_ready_i;
  assign cmd_addr_o  = addr_q;
  assign cmd_len_o   = sel_len;
  assign cmd_write_o = wr_q;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    wr_d    = wr_q;
    xfer_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i && (req_beats_i != '0)) begin
          state_d = ST_RUN;
          addr_d  = req_addr_i;
          rem_d   = req_beats_i;
          wr_d    = req_write_i;
          xfer_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (cmd_fire) begin
          addr_d  = addr_q + AW'(sel_len) * AW'(BEAT_BYTES);
          rem_d   = rem_q - CW'(sel_len);
          xfer_en = 1'b1;
          if (rem_q == CW'(sel_len)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      wr_q   <= 1'b0;
    end else if (xfer_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      wr_q   <= wr_d;
    end
  end
endmodule

// File: rtl/bse_checker.sv
module bse_checker #(
  parameter int  AW         = 32,
  parameter int  CW         = 16,
  parameter int  BEAT_BYTES = 4,
  parameter int  MAX_OUT    = 4,
  localparam int LW         = 5,
  localparam int CAPW       = $clog2(MAX_OUT),
  localparam int NW         = $clog2(MAX_OUT + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      cfg_len_en_i,
  input logic            cfg_anylen_i,
  input logic            cfg_align_i,
  input logic [CAPW-1:0] cfg_rd_cap_i,
  input logic [CAPW-1:0] cfg_wr_cap_i,
  input logic            req_ready_o,
  input logic            cmd_valid_o,
  input logic            cmd_ready_i,
  input logic [AW-1:0]   cmd_addr_o,
  input logic [LW-1:0]   cmd_len_o,
  input logic            cmd_write_o,
  input logic            rd_done_i,
  input logic            wr_done_i
);
  logic [NW-1:0] rd_out, wr_out;
  logic          fire;
  logic [LW-1:0] top_len;
  logic [AW-1:0] align_mask;

  assign fire       = cmd_valid_o && cmd_ready_i;
  assign top_len    = cfg_len_en_i[2] ? LW'(16) : cfg_len_en_i[1] ? LW'(8) :
                      cfg_len_en_i[0] ? LW'(4) : LW'(1);
  assign align_mask = AW'(cmd_len_o) * AW'(BEAT_BYTES) - AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_out <= '0;
      wr_out <= '0;
    end else begin
      rd_out <= rd_out + NW'(fire && !cmd_write_o) - NW'(rd_done_i && (rd_out != '0));
      wr_out <= wr_out + NW'(fire && cmd_write_o) - NW'(wr_done_i && (wr_out != '0));
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cfg_anylen_i |-> (cmd_len_o == 1 || cmd_len_o == 4 || cmd_len_o == 8 || cmd_len_o == 16)); // R2
  AST_ANY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cfg_anylen_i |-> (cmd_len_o != 0) && (cmd_len_o <= top_len)); // R3
  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cfg_align_i && !cfg_anylen_i |-> ((cmd_addr_o & align_mask) == '0)); // R4
  AST_NO_OVERFLOW_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_write_o |-> (rd_out <= NW'(cfg_rd_cap_i))); // R7
  AST_NO_OVERFLOW_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_write_o |-> (wr_out <= NW'(cfg_wr_cap_i))); // R7
  AST_HOLD_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o); // R8
endmodule

bind burst_split_engine bse_checker #(
  .AW(AW), .CW(CW), .BEAT_BYTES(BEAT_BYTES), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_len_en_i (cfg_len_en_i),
  .cfg_anylen_i (cfg_anylen_i),
  .cfg_align_i  (cfg_align_i),
  .cfg_rd_cap_i (cfg_rd_cap_i),
  .cfg_wr_cap_i (cfg_wr_cap_i),
  .req_ready_o  (req_ready_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_len_o    (cmd_len_o),
  .cmd_write_o  (cmd_write_o),
  .rd_done_i    (rd_done_i),
  .wr_done_i    (wr_done_i)
);

// File: tb/sim_burst_split_engine.sv
module sim_burst_split_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [2:0]  len_en;
  logic        anylen, align;
  logic [1:0]  rd_cap, wr_cap;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic [15:0] req_beats;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_len;
  logic        rd_done, wr_done;

  int errors = 0;
  int checks = 0;

  burst_split_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_len_en_i(len_en), .cfg_anylen_i(anylen), .cfg_align_i(align),
    .cfg_rd_cap_i(rd_cap), .cfg_wr_cap_i(wr_cap),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_beats_i(req_beats), .req_write_i(req_write),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr),
    .cmd_len_o(cmd_len), .cmd_write_o(cmd_write),
    .rd_done_i(rd_done), .wr_done_i(wr_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  en;
    logic        any;
    logic        al;
    logic [31:0] addr;
    logic [15:0] beats;
    logic        wr;
    logic [7:0]  nb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b111, 1'b0, 1'b0, 32'h1000, 16'd42, 1'b0, 8'd5},  // 16,16,8,1,1
    '{3'b100, 1'b1, 1'b0, 32'h2000, 16'd42, 1'b1, 8'd3},  // 16,16,10
    '{3'b000, 1'b1, 1'b0, 32'h0000, 16'd3,  1'b0, 8'd3},  // 1,1,1
    '{3'b011, 1'b0, 1'b0, 32'h0000, 16'd13, 1'b1, 8'd3},  // 8,4,1
    '{3'b111, 1'b0, 1'b1, 32'h0010, 16'd30, 1'b0, 8'd5},  // 4,8,16,1,1
    '{3'b100, 1'b1, 1'b1, 32'h0020, 16'd20, 1'b1, 8'd9},  // 8x1, then 12
    '{3'b001, 1'b0, 1'b0, 32'h0100, 16'd4,  1'b1, 8'd1},  // 4
    '{3'b111, 1'b0, 1'b0, 32'h0000, 16'd16, 1'b0, 8'd1}   // 16
  };

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] en, input logic any, input logic al,
                                 input logic [31:0] a, input int rem);
    for (int i = 0; i < 3; i++) begin
      int sz;
      sz = 16 >> i;
      if (en[2-i] && (any || rem >= sz) && (!al || (a % (sz * 4)) == 0))
        return (rem < sz) ? rem : sz;
    end
    return 1;
  endfunction

  task automatic run_vec(input vec_t v);
    int n, sum, rem, el;
    logic [31:0] ea;
    logic pr, pw;
    string tag;
    tag = v.any ? "R3" : (v.al ? "R4" : "R2");
    if (v.al && v.any) tag = "R4";
    @(negedge clk);
    len_en = v.en; anylen = v.any; align = v.al;
    req_valid = 1'b1; req_addr = v.addr; req_beats = v.beats; req_write = v.wr;
    @(negedge clk);
    req_valid = 1'b0;
    ea = v.addr; rem = int'(v.beats); n = 0; sum = 0; pr = 1'b0; pw = 1'b0;
    for (int cyc = 0; cyc < 200 && rem > 0; cyc++) begin
      rd_done = pr; wr_done = pw; pr = 1'b0; pw = 1'b0;
      if (cmd_valid) begin
        el = exp_len(v.en, v.any, v.al, ea, rem);
        chk(int'(cmd_len) == el, {tag, " burst length"}, cmd_len, el);
        chk(cmd_addr == ea, "R5 burst address", cmd_addr, ea);
        chk(cmd_write == v.wr, "R5 direction", cmd_write, v.wr);
        ea = ea + 32'(el * 4);
        rem = rem - el;
        sum = sum + int'(cmd_len);
        n++;
        if (v.wr) pw = 1'b1; else pr = 1'b1;
      end
      @(negedge clk);
    end
    rd_done = pr; wr_done = pw;
    chk(n == int'(v.nb), {tag, " burst count"}, n, v.nb);
    chk(sum == int'(v.beats), "R5 total beats", sum, v.beats);
    chk(req_ready == 1'b1, "R8 idle after last burst", req_ready, 1);
    @(negedge clk);
    rd_done = 1'b0; wr_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hs;
    rst_n = 1'b0; len_en = 3'b000; anylen = 1'b0; align = 1'b0;
    rd_cap = 2'd3; wr_cap = 2'd3;
    req_valid = 1'b0; req_addr = '0; req_beats = '0; req_write = 1'b0;
    cmd_ready = 1'b1; rd_done = 1'b0; wr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R6: zero-beat request
    @(negedge clk);
    len_en = 3'b111; anylen = 1'b0; align = 1'b0;
    req_valid = 1'b1; req_addr = 32'h500; req_beats = 16'd0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b1, "R6 zero request leaves engine idle", req_ready, 1);
    chk(cmd_valid == 1'b0, "R6 zero request issues nothing", cmd_valid, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R6 still no command", cmd_valid, 0);
    end

    // R7: read cap of two outstanding, singles only
    len_en = 3'b000; rd_cap = 2'd1; wr_cap = 2'd0;
    req_valid = 1'b1; req_addr = 32'h300; req_beats = 16'd6; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    hs = 0;
    for (int k = 0; k < 6; k++) begin
      if (cmd_valid) hs++;
      @(negedge clk);
    end
    chk(hs == 2, "R7 read bursts before cap", hs, 2);
    chk(cmd_valid == 1'b0, "R7 read withheld at cap", cmd_valid, 0);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    chk(cmd_valid == 1'b1, "R7 completion frees a read slot", cmd_valid, 1);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 read withheld again", cmd_valid, 0);
    rd_done = 1'b1;
    for (int k = 0; k < 40 && !req_ready; k++) @(negedge clk);
    chk(req_ready == 1'b1, "R7 read request drains", req_ready, 1);
    repeat (4) @(negedge clk);
    rd_done = 1'b0;

    // R7: write cap of one, independent of read cap
    req_valid = 1'b1; req_addr = 32'h600; req_beats = 16'd3; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_valid == 1'b1, "R7 first write issued", cmd_valid, 1);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 write withheld at cap", cmd_valid, 0);
    wr_done = 1'b1;
    for (int k = 0; k < 40 && !req_ready; k++) @(negedge clk);
    chk(req_ready == 1'b1, "R7 write request drains", req_ready, 1);
    repeat (4) @(negedge clk);
    wr_done = 1'b0;

    // R8: back-pressure holds command
    rd_cap = 2'd3; wr_cap = 2'd3; len_en = 3'b111; cmd_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h400; req_beats = 16'd8; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_valid == 1'b1, "R8 command presented", cmd_valid, 1);
    chk(cmd_len == 5'd8, "R8 command length", cmd_len, 8);
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b1, "R8 valid held under stall", cmd_valid, 1);
    chk(cmd_addr == 32'h400, "R8 address held under stall", cmd_addr, 32'h400);
    chk(cmd_len == 5'd8, "R8 length held under stall", cmd_len, 8);
    chk(req_ready == 1'b0, "R8 busy while request runs", req_ready, 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R8 done after single burst", cmd_valid, 0);
    chk(req_ready == 1'b1, "R8 idle again", req_ready, 1);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule